// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small set of byte-wide control registers on a synchronous 8-bit I/O bus. It decodes a 12-bit I/O address against one of two selectable base addresses. It accepts single-cycle read and write strobes and acknowledges each access it owns one cycle later, returning the read data at the same time.

The bank holds three registers:

- A fixed product identifier, which also carries the active-low drive bit for a programmable LED.
- A read-only byte that reports the logic revision and three build flags.
- A control register. It reports the firmware-image jumper, offers a software override that picks the firmware image and has priority over the jumper, and sets the line mode of one serial port.

The block drives three outputs: the LED, the effective firmware-select line and the 2-bit serial-mode code.

Top module: `brdctl_regs`

## Requirements
- R1: With `base_alt`=0 the bank answers at 0xCA0..0xCA2; with `base_alt`=1 it answers at 0xC90..0xC92. Offset 0 is the product register, 1 the revision register and 2 the control register. An access to any other address is not acknowledged, returns 0 on `io_rdata` and changes no state.
- R2: A read or write strobe to an owned address raises `io_ack` for exactly the cycle after the strobe cycle. A read returns its data on `io_rdata` in that same cycle. In every cycle that does not follow an owned read, `io_rdata` is 0.
- R3: The product register reads as {LED bit, 7'b0000001}. Bits 6..0 are not changed by writes.
- R4: Bit 7 of the product register is writable and drives `led_n` directly; 0 lights the LED. `led_n` changes only through a write to that bit.
- R5: The revision register reads {revision[4:0], extended-temperature, custom, beta} from bit 7 down to bit 0. Writes to it have no effect.
- R6: Control bit 7 reads the jumper input `fw_jumper` after a two-flop synchronizer (0 = jumper fitted, backup image). Writes to this bit are ignored.
- R7: Control bit 6 is the override enable and bit 5 the software select (1 = primary). `fw_primary` equals bit 5 while bit 6 is 1, and the synchronized jumper otherwise.
- R8: Control bits 4..3 hold the serial mode (00 RS-232, 01 RS-422, 10 RS-485, 11 reserved). They drive `ser_mode`, and all four codes are stored and read back as written.
- R9: Control bits 2..0 always read 0, and writes to them have no effect.
- R10: After reset, `led_n`=1, the override is 0, the software select is 1 and the serial mode is 00. The control register therefore reads 0xA0 with the jumper open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_alt | input | 1 | 0 selects base 0xCA0, 1 selects base 0xC90 |
| io_addr | input | 12 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rdata | output | 8 | Read data, valid with io_ack, 0 otherwise |
| io_ack | output | 1 | Acknowledge, one cycle after an owned access |
| fw_jumper | input | 1 | Firmware jumper sense, 0 = fitted (backup) |
| led_n | output | 1 | Programmable LED drive, active low |
| fw_primary | output | 1 | Effective firmware select, 1 = primary image |
| ser_mode | output | 2 | Serial line mode code |

## Verification
Every stored field drives an output pin directly, so a corrupted LED, override, select or mode bit shows on `led_n`, `fw_primary` or `ser_mode` in the cycle after the bad write. A wrong decode shows as a missing or extra `io_ack` one cycle after the strobe, or as a register changed by an access at a foreign address. That register change only becomes visible at the next read or on the output pin it drives. Jumper faults appear two cycles after the input moves, both in control bit 7 and in `fw_primary` when no override is set.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_REGS = 3;

    // bit positions that software decodes
    localparam int unsigned LED_BIT   = 7;
    localparam int unsigned JMP_BIT   = 7;
    localparam int unsigned OVR_BIT   = 6;
    localparam int unsigned SWSEL_BIT = 5;
    localparam int unsigned MODE_LSB  = 3;

    localparam logic [6:0] PROD_ID = 7'b0000001;

    typedef enum logic [1:0] {
        REG_PROD = 2'd0,
        REG_REV  = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SM_RS232 = 2'b00,
        SM_RS422 = 2'b01,
        SM_RS485 = 2'b10,
        SM_RSVD  = 2'b11
    } ser_mode_e;

    typedef struct packed {
        logic      led_off;
        logic      ovr_en;
        logic      sw_primary;
        ser_mode_e mode;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RST = '{
        led_off:    1'b1,
        ovr_en:     1'b0,
        sw_primary: 1'b1,
        mode:       SM_RS232
    };

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

endpackage

// File: rtl/brdctl_decode.sv
module brdctl_decode
    import brdctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BASE_MAIN = 12'hCA0,
    parameter int unsigned BASE_ALT  = 12'hC90
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              base_alt,
    output logic              hit,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] MAIN_A = ADDR_W'(BASE_MAIN);
    localparam logic [ADDR_W-1:0] ALT_A  = ADDR_W'(BASE_ALT);
    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NUM_REGS);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        base = base_alt ? ALT_A : MAIN_A;
        diff = addr - base;
        hit  = (addr >= base) && (diff < SPAN);
        sel  = hit ? reg_sel_e'(diff[1:0]) : REG_NONE;
    end

endmodule

// File: rtl/brdctl_sync.sv
module brdctl_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/brdctl_ctrl.sv
module brdctl_ctrl
    import brdctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_regs_t        regs_q
);

    ctrl_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (sel)
                REG_PROD: regs_d.led_off = wdata[LED_BIT];
                REG_CTRL: begin
                    regs_d.ovr_en     = wdata[OVR_BIT];
                    regs_d.sw_primary = wdata[SWSEL_BIT];
                    regs_d.mode       = ser_mode_e'(wdata[MODE_LSB +: 2]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= CTRL_RST;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/brdctl_regs.sv
module brdctl_regs
    import brdctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BASE_MAIN   = 12'hCA0,
    parameter int unsigned BASE_ALT    = 12'hC90,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [4:0]  REV_LEVEL   = 5'd3,
    parameter logic        EXT_TEMP    = 1'b1,
    parameter logic        CUSTOM      = 1'b0,
    parameter logic        BETA        = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_alt,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [7:0]        io_rdata,
    output logic              io_ack,
    input  logic              fw_jumper,
    output logic              led_n,
    output logic              fw_primary,
    output logic [1:0]        ser_mode
);

    localparam logic [DATA_W-1:0] REV_BYTE = {REV_LEVEL, EXT_TEMP, CUSTOM, BETA};

    logic       hit;
    reg_sel_e   sel;
    logic       jumper_s;
    ctrl_regs_t regs_q;
    logic       ovr_en;
    logic       sw_primary;
    bus_state_t bus_d;
    bus_state_t bus_q;
    logic [DATA_W-1:0] rd_mux;

    brdctl_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_MAIN(BASE_MAIN),
        .BASE_ALT (BASE_ALT)
    ) u_decode (
        .addr    (io_addr),
        .base_alt(base_alt),
        .hit     (hit),
        .sel     (sel)
    );

    brdctl_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (fw_jumper),
        .dout (jumper_s)
    );

    brdctl_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (io_wr && hit),
        .sel   (sel),
        .wdata (io_wdata),
        .regs_q(regs_q)
    );

    assign ovr_en     = regs_q.ovr_en;
    assign sw_primary = regs_q.sw_primary;

    always_comb begin
        case (sel)
            REG_PROD: rd_mux = {regs_q.led_off, PROD_ID};
            REG_REV:  rd_mux = REV_BYTE;
            REG_CTRL: rd_mux = {jumper_s, regs_q.ovr_en, regs_q.sw_primary,
                                regs_q.mode, 3'b000};
            default:  rd_mux = '0;
        endcase
        bus_d.ack   = hit && (io_rd || io_wr);
        bus_d.rdata = (hit && io_rd) ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign io_ack     = bus_q.ack;
    assign io_rdata   = bus_q.rdata;
    assign led_n      = regs_q.led_off;
    assign ser_mode   = regs_q.mode;
    assign fw_primary = ovr_en ? sw_primary : jumper_s;

endmodule

// File: rtl/brdctl_regs_chk.sv
module brdctl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_rd,
    input logic       io_wr,
    input logic       io_ack,
    input logic [7:0] io_rdata,
    input logic       led_n,
    input logic [1:0] ser_mode,
    input logic       fw_primary,
    input logic       ovr_en,
    input logic       sw_primary
);

    AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> $past(io_rd || io_wr)); // R2

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> (io_rdata == 8'h00)); // R2

    AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en |-> (fw_primary == sw_primary)); // R7

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(led_n)); // R4

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(ser_mode)); // R8

endmodule

bind brdctl_regs brdctl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_ack    (io_ack),
    .io_rdata  (io_rdata),
    .led_n     (led_n),
    .ser_mode  (ser_mode),
    .fw_primary(fw_primary),
    .ovr_en    (ovr_en),
    .sw_primary(sw_primary)
);

// File: tb/brdctl_regs_test.sv
`timescale 1ns/1ps
module brdctl_regs_test;

    localparam logic [7:0] REV_EXP = 8'h1D; // {5'd3,1,0,1}

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_alt = 1'b0;
    logic [11:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        fw_jumper = 1'b1;
    logic [7:0]  io_rdata;
    logic        io_ack;
    logic        led_n;
    logic        fw_primary;
    logic [1:0]  ser_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    brdctl_regs uut (
        .clk(clk), .rst_n(rst_n), .base_alt(base_alt),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
        .io_rdata(io_rdata), .io_ack(io_ack), .fw_jumper(fw_jumper),
        .led_n(led_n), .fw_primary(fw_primary), .ser_mode(ser_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d, output logic ack);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        ack = io_ack;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [7:0] d, output logic ack);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        d = io_rdata; ack = io_ack;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic wr_ok(input string req, input logic [11:0] a, input logic [7:0] d);
        logic ack;
        do_write(a, d, ack);
        check(req, {7'b0, ack}, 8'h01);
    endtask

    task automatic rd_expect(input string req, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] d; logic ack;
        do_read(a, d, ack);
        check(req, {7'b0, ack}, 8'h01);
        check(req, d, exp);
    endtask

    task automatic test_reset();
        check("R10 led_n", {7'b0, led_n}, 8'h01);
        check("R10 ser_mode", {6'b0, ser_mode}, 8'h00);
        check("R10 fw_primary", {7'b0, fw_primary}, 8'h01);
        rd_expect("R10 ctrl", 12'hCA2, 8'hA0);
        rd_expect("R3 prod", 12'hCA0, 8'h81);
        rd_expect("R5 rev", 12'hCA1, REV_EXP);
    endtask

    task automatic test_ack_timing();
        logic [7:0] d; logic ack;
        do_read(12'hCA1, d, ack);
        check("R2 ack on read", {7'b0, ack}, 8'h01);
        check("R2 data with ack", d, REV_EXP);
        @(posedge clk); #1;
        check("R2 ack drops", {7'b0, io_ack}, 8'h00);
        check("R2 rdata idle zero", io_rdata, 8'h00);
    endtask

    task automatic test_led();
        wr_ok("R4 write", 12'hCA0, 8'h00);
        check("R4 led on", {7'b0, led_n}, 8'h00);
        rd_expect("R3 prod led0", 12'hCA0, 8'h01);
        wr_ok("R3 write lows", 12'hCA0, 8'h7F);
        rd_expect("R3 id fixed", 12'hCA0, 8'h01);
        wr_ok("R4 write", 12'hCA0, 8'h80);
        check("R4 led off", {7'b0, led_n}, 8'h01);
        rd_expect("R3 prod led1", 12'hCA0, 8'h81);
    endtask

    task automatic test_rev_ro();
        wr_ok("R5 write", 12'hCA1, 8'hFF);
        rd_expect("R5 unchanged", 12'hCA1, REV_EXP);
        wr_ok("R5 write", 12'hCA1, 8'h00);
        rd_expect("R5 unchanged", 12'hCA1, REV_EXP);
    endtask

    task automatic test_mode();
        for (int m = 0; m < 4; m++) begin
            wr_ok("R8 write", 12'hCA2, 8'h20 | 8'(m << 3));
            check("R8 ser_mode pin", {6'b0, ser_mode}, 8'(m));
            rd_expect("R8 readback", 12'hCA2, 8'hA0 | 8'(m << 3));
        end
        wr_ok("R9 write low bits", 12'hCA2, 8'h27);
        rd_expect("R9 low bits zero", 12'hCA2, 8'hA0);
        check("R9 mode after", {6'b0, ser_mode}, 8'h00);
    endtask

    task automatic test_jumper_override();
        fw_jumper = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R6 fw follows jumper", {7'b0, fw_primary}, 8'h00);
        rd_expect("R6 jumper bit", 12'hCA2, 8'h20);
        wr_ok("R6 write jumper bit", 12'hCA2, 8'hA0);
        rd_expect("R6 jumper ignored", 12'hCA2, 8'h20);
        wr_ok("R7 ovr primary", 12'hCA2, 8'h60);
        check("R7 override primary", {7'b0, fw_primary}, 8'h01);
        wr_ok("R7 ovr backup", 12'hCA2, 8'h40);
        check("R7 override backup", {7'b0, fw_primary}, 8'h00);
        fw_jumper = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R7 override beats jumper", {7'b0, fw_primary}, 8'h00);
        rd_expect("R6 jumper open", 12'hCA2, 8'hC0);
        wr_ok("R7 clear ovr", 12'hCA2, 8'h00);
        check("R7 back to jumper", {7'b0, fw_primary}, 8'h01);
    endtask

    task automatic test_decode();
        logic [7:0] d; logic ack;
        base_alt = 1'b1;
        rd_expect("R1 alt prod", 12'hC90, 8'h81);
        rd_expect("R1 alt rev", 12'hC91, REV_EXP);
        do_read(12'hCA0, d, ack);
        check("R1 main ignored in alt ack", {7'b0, ack}, 8'h00);
        check("R1 main ignored in alt data", d, 8'h00);
        do_read(12'hC93, d, ack);
        check("R1 past end", {7'b0, ack}, 8'h00);
        do_read(12'hC8F, d, ack);
        check("R1 below base", {7'b0, ack}, 8'h00);
        base_alt = 1'b0;
        do_write(12'hC90, 8'h00, ack);
        check("R1 foreign write ack", {7'b0, ack}, 8'h00);
        check("R1 foreign write led", {7'b0, led_n}, 8'h01);
        do_write(12'hCA3, 8'hFF, ack);
        check("R1 CA3 unowned", {7'b0, ack}, 8'h00);
        rd_expect("R1 ctrl intact", 12'hCA2, 8'h80);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        test_reset();
        test_ack_timing();
        test_led();
        test_rev_ro();
        test_mode();
        test_jumper_override();
        test_decode();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule